// File: doc/BRIEF.md
# SDRAM Initialisation and Control-Command Sequencer

This block is the command-level control sequencer of an external SDRAM controller. It holds three small registers that are written over a simple byte-enabled write bus: a configuration register, a timing register and a refresh-rate register. From them it produces the SDRAM clock enable, the four active-low command strobes and the address bus. Data-path reads and writes are out of scope.

When reset is released, the block runs the SDRAM power-up sequence by itself: a power-up wait, one precharge of all banks, a run of auto-refresh commands, and one mode-register load. It reruns the same sequence whenever software rewrites any of the three lower bytes of the configuration register. A write that touches only the upper byte changes the self-refresh request and does not restart initialisation. Between these events it issues periodic auto-refresh, paced by the refresh-rate register. It enters and leaves self-refresh on request, and holds a quiet exit period after leaving.

Top module: `sdseq_top`

## Requirements
- R1: On a mode-register load (strobes {cs_n,ras_n,cas_n,we_n} = 4'b0000), address bits [9:7] are 0 and address bit 3 is 0.
- R2: On a mode-register load, address bits [6:4] are 3 when configuration bit 8 (register address 0) is 1, and 2 when it is 0.
- R3: On a mode-register load, address bits [2:0] are 3 when configuration bit 0 is 1, and 2 when it is 0.
- R4: After reset the block runs initialisation without any request. It drives NOP (4'b0111) for at least PWR_WAIT_CYC cycles, then a precharge-all (4'b0010 with address bit 10 high), then REF_N auto-refreshes (4'b0001), then one mode-register load.
- R5: During initialisation, consecutive commands are spaced tRFC+1 cycles apart, and busy falls tRFC cycles after the mode-register load. tRFC is timing-register (address 1) bits [7:0].
- R6: A configuration write with any of byte enables 0, 1 or 2 set restarts the full initialisation. A write with only byte enable 3 set does not.
- R7: Configuration bit 31 set causes a self-refresh entry: an auto-refresh command issued with clock enable low. Clock enable then stays low with NOP for as long as the bit stays set. Clearing the bit drives clock enable high.
- R8: After self-refresh exit, the block drives NOP and holds busy high for exactly tXSR cycles. tXSR is timing-register bits [15:8]. Busy is also high throughout initialisation.
- R9: Outside initialisation, self-refresh and exit, the block issues an auto-refresh every RATE+1 cycles, where RATE is refresh-register (address 2) bits [15:0]. No refresh is issued while in self-refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 config, 1 timing, 2 refresh rate |
| reg_be_i | input | 4 | Byte enables for the write |
| reg_wdata_i | input | 32 | Write data |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_addr_o | output | ADDR_W | Command address bus |
| busy_o | output | 1 | High during initialisation and self-refresh exit |

## Verification
The bench builds the block with PWR_WAIT_CYC set to 20 instead of a full microsecond-scale wait, so three complete initialisation runs fit in a short run. The other parameters keep their defaults: eight refreshes per initialisation and a 13-bit address. With the timing register programmed to tRFC = 3 and tXSR = 5 and the refresh rate set to 40, the bench can measure command spacing, the exit window and several refresh periods exactly. It can also hold self-refresh long enough to cover two missed refresh periods.

// File: rtl/sdseq_pkg.sv
// Shared definitions for the SDRAM control sequencer.
// Assumes a single-rank SDRAM driven with the classic four-strobe command set.
package sdseq_pkg;

    // Command strobes {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_LMR = 4'b0000
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR, ST_PRE, ST_REF, ST_LMR, ST_GAP,
        ST_IDLE, ST_AREF, ST_SRIN, ST_SR, ST_SREXIT
    } seq_state_e;

    localparam logic [1:0] RA_CFG  = 2'd0;
    localparam logic [1:0] RA_TIM  = 2'd1;
    localparam logic [1:0] RA_RATE = 2'd2;
    localparam int         RATE_W  = 16;

endpackage

// File: rtl/sdseq_regs.sv
// Register store for the SDRAM control sequencer.
// Holds the mode fields, self-refresh request, timing counts and refresh rate.
// Emits a one-cycle restart pulse when any lower config byte is written.
// Assumes the write bus is one cycle per write, with no read path.
module sdseq_regs
    import sdseq_pkg::*;
#(
    parameter logic [7:0]        TRFC_RST = 8'd7,
    parameter logic [7:0]        XSR_RST  = 8'd8,
    parameter logic [RATE_W-1:0] RATE_RST = 16'd975
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [3:0]        be_i,
    input  logic [31:0]       wdata_i,
    output logic              len8_o,
    output logic              cas3_o,
    output logic              sr_req_o,
    output logic [7:0]        trfc_o,
    output logic [7:0]        xsr_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              restart_o
);

    logic cfg_wr, tim_wr, rate_wr;
    logic unused_wdata;

    assign cfg_wr       = wr_i && (addr_i == RA_CFG);
    assign tim_wr       = wr_i && (addr_i == RA_TIM);
    assign rate_wr      = wr_i && (addr_i == RA_RATE);
    assign unused_wdata = ^wdata_i[30:16];

    // Byte-enabled field updates and restart pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len8_o    <= 1'b0;
            cas3_o    <= 1'b1;
            sr_req_o  <= 1'b0;
            trfc_o    <= TRFC_RST;
            xsr_o     <= XSR_RST;
            rate_o    <= RATE_RST;
            restart_o <= 1'b0;
        end else begin
            restart_o <= cfg_wr && (|be_i[2:0]);
            if (cfg_wr && be_i[0]) len8_o   <= wdata_i[0];
            if (cfg_wr && be_i[1]) cas3_o   <= wdata_i[8];
            if (cfg_wr && be_i[3]) sr_req_o <= wdata_i[31];
            if (tim_wr && be_i[0]) trfc_o   <= wdata_i[7:0];
            if (tim_wr && be_i[1]) xsr_o    <= wdata_i[15:8];
            if (rate_wr && be_i[0]) rate_o[7:0]  <= wdata_i[7:0];
            if (rate_wr && be_i[1]) rate_o[15:8] <= wdata_i[15:8];
        end
    end

    // R6: an upper-byte-only config write never raises restart
    p_upper_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_CFG && be_i == 4'b1000) |=> !restart_o);

endmodule

// File: rtl/sdseq_refresh.sv
// Periodic refresh timer.
// Counts down from the programmed rate while enabled and raises a pending
// flag on expiry. The flag is cleared by an acknowledge from the sequencer.
// Assumes a disabled timer reloads, so refresh resumes a full period later.
module sdseq_refresh
    import sdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              ack_i,
    output logic              pend_o
);

    logic [RATE_W-1:0] cnt_q;

    // Down-counter with reload and a sticky pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= rate_i;
            pend_o <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= rate_i;
            pend_o <= pend_o && !ack_i;
        end else if (cnt_q == '0) begin
            cnt_q  <= rate_i;
            pend_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            pend_o <= pend_o && !ack_i;
        end
    end

    // R9: no new refresh request while the timer is suppressed
    p_no_req_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !$rose(pend_o));

endmodule

// File: rtl/sdseq_fsm.sv
// Command sequencer for the SDRAM control path.
// Runs power-up initialisation, periodic refresh, and self-refresh entry and exit.
// All command outputs are registered.
// Assumes ADDR_W >= 11, so that address bit 10 exists for precharge-all.
module sdseq_fsm
    import sdseq_pkg::*;
#(
    parameter int PWR_WAIT_CYC = 25000,
    parameter int REF_N        = 8,
    parameter int ADDR_W       = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              len8_i,
    input  logic              cas3_i,
    input  logic              sr_req_i,
    input  logic [7:0]        trfc_i,
    input  logic [7:0]        xsr_i,
    input  logic              ref_pend_i,
    output logic              ref_ack_o,
    output logic              ref_en_o,
    output logic              cke_o,
    output sd_cmd_e           cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o
);

    localparam int PW_W = $clog2(PWR_WAIT_CYC + 1);
    localparam int CW   = (PW_W > 8) ? PW_W : 8;
    localparam int RW   = $clog2(REF_N + 2);

    seq_state_e        state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d, gap_last, xsr_last;
    logic [RW-1:0]     refs_q, refs_d;
    logic              init_q, init_d, cke_d;
    sd_cmd_e           cmd_d;
    logic [ADDR_W-1:0] addr_d;

    assign gap_last = (trfc_i == 8'd0) ? '0 : CW'(trfc_i - 8'd1);
    assign xsr_last = (xsr_i == 8'd0)  ? '0 : CW'(xsr_i - 8'd1);
    assign busy_o   = init_q || (state_q == ST_SREXIT);
    assign ref_en_o = !busy_o && (state_q == ST_IDLE || state_q == ST_AREF || state_q == ST_GAP);

    // Next-state, next-command and counter logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        refs_d    = refs_q;
        init_d    = init_q;
        cmd_d     = CMD_NOP;
        cke_d     = 1'b1;
        addr_d    = '0;
        ref_ack_o = 1'b0;
        if (restart_i) begin
            state_d = ST_PWR;
            cnt_d   = '0;
            init_d  = 1'b1;
        end else begin
            case (state_q)
                ST_PWR: begin
                    if (cnt_q == CW'(PWR_WAIT_CYC - 1)) begin
                        state_d = ST_PRE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PRE: begin
                    cmd_d      = CMD_PRE;
                    addr_d[10] = 1'b1;
                    refs_d     = '0;
                    cnt_d      = '0;
                    state_d    = ST_GAP;
                end
                ST_REF: begin
                    cmd_d   = CMD_REF;
                    refs_d  = refs_q + 1'b1;
                    cnt_d   = '0;
                    state_d = ST_GAP;
                end
                ST_LMR: begin
                    cmd_d       = CMD_LMR;
                    addr_d[2:0] = len8_i ? 3'd3 : 3'd2;
                    addr_d[6:4] = cas3_i ? 3'd3 : 3'd2;
                    refs_d      = refs_q + 1'b1;
                    cnt_d       = '0;
                    state_d     = ST_GAP;
                end
                ST_GAP: begin
                    if (cnt_q >= gap_last) begin
                        cnt_d = '0;
                        if (!init_q)                     state_d = ST_IDLE;
                        else if (refs_q < RW'(REF_N))    state_d = ST_REF;
                        else if (refs_q == RW'(REF_N))   state_d = ST_LMR;
                        else begin
                            state_d = ST_IDLE;
                            init_d  = 1'b0;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (sr_req_i)        state_d = ST_SRIN;
                    else if (ref_pend_i) state_d = ST_AREF;
                end
                ST_AREF: begin
                    cmd_d     = CMD_REF;
                    ref_ack_o = 1'b1;
                    cnt_d     = '0;
                    state_d   = ST_GAP;
                end
                ST_SRIN: begin
                    cmd_d   = CMD_REF;
                    cke_d   = 1'b0;
                    state_d = ST_SR;
                end
                ST_SR: begin
                    cke_d = 1'b0;
                    if (!sr_req_i) begin
                        cke_d   = 1'b1;
                        cnt_d   = '0;
                        state_d = ST_SREXIT;
                    end
                end
                ST_SREXIT: begin
                    if (cnt_q >= xsr_last) begin
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_PWR;
            endcase
        end
    end

    // State and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWR;
            cnt_q   <= '0;
            refs_q  <= '0;
            init_q  <= 1'b1;
            cmd_o   <= CMD_NOP;
            cke_o   <= 1'b1;
            addr_o  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            refs_q  <= refs_d;
            init_q  <= init_d;
            cmd_o   <= cmd_d;
            cke_o   <= cke_d;
            addr_o  <= addr_d;
        end
    end

    // R1: reserved mode bits stay clear
    p_mode_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_LMR) |-> (addr_o[9:7] == 3'd0 && addr_o[3] == 1'b0));
    // R2: CAS latency field is one of the two supported codes
    p_cas_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_LMR) |-> (addr_o[6:4] == 3'd2 || addr_o[6:4] == 3'd3));
    // R4: precharge is always the all-banks form
    p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE) |-> addr_o[10]);
    // R6: a restart makes the block busy on the next cycle
    p_restart_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> busy_o);
    // R7: clock enable held low means the command bus is quiet
    p_sr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && $past(!cke_o)) |-> (cmd_o == CMD_NOP));
    // R8: leaving self-refresh starts a busy exit window
    p_exit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> busy_o);

endmodule

// File: rtl/sdseq_top.sv
// SDRAM initialisation and control-command sequencer, top level.
// Connects the register store, the refresh timer and the command sequencer,
// and splits the command onto the four strobes.
// Assumes the bus and the SDRAM run on the same clock.
module sdseq_top
    import sdseq_pkg::*;
#(
    parameter int PWR_WAIT_CYC = 25000,
    parameter int REF_N        = 8,
    parameter int ADDR_W       = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [3:0]        reg_be_i,
    input  logic [31:0]       reg_wdata_i,
    output logic              sd_cke_o,
    output logic              sd_cs_n_o,
    output logic              sd_ras_n_o,
    output logic              sd_cas_n_o,
    output logic              sd_we_n_o,
    output logic [ADDR_W-1:0] sd_addr_o,
    output logic              busy_o
);

    logic              len8, cas3, sr_req, restart, ref_pend, ref_ack, ref_en;
    logic [7:0]        trfc, xsr;
    logic [RATE_W-1:0] rate;
    sd_cmd_e           cmd;

    sdseq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .be_i(reg_be_i), .wdata_i(reg_wdata_i), .len8_o(len8), .cas3_o(cas3),
        .sr_req_o(sr_req), .trfc_o(trfc), .xsr_o(xsr), .rate_o(rate),
        .restart_o(restart)
    );

    sdseq_refresh u_refresh (
        .clk(clk), .rst_n(rst_n), .en_i(ref_en), .rate_i(rate),
        .ack_i(ref_ack), .pend_o(ref_pend)
    );

    sdseq_fsm #(
        .PWR_WAIT_CYC(PWR_WAIT_CYC), .REF_N(REF_N), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .len8_i(len8),
        .cas3_i(cas3), .sr_req_i(sr_req), .trfc_i(trfc), .xsr_i(xsr),
        .ref_pend_i(ref_pend), .ref_ack_o(ref_ack), .ref_en_o(ref_en),
        .cke_o(sd_cke_o), .cmd_o(cmd), .addr_o(sd_addr_o), .busy_o(busy_o)
    );

    assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;

endmodule

// File: tb/sdseq_top_tb_top.sv
// Directed bench for the SDRAM control sequencer: one task per scenario.
module sdseq_top_tb_top;

    localparam int PW     = 20;
    localparam int NREF   = 8;
    localparam int AW     = 13;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

    logic          clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
    logic [1:0]    ra = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wd = '0;
    logic          cke, cs_n, ras_n, cas_n, we_n, busy;
    logic [AW-1:0] addr;
    int            cyc = 0, checks = 0, fails = 0;
    bit            done = 1'b0;

    sdseq_top #(.PWR_WAIT_CYC(PW), .REF_N(NREF), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(ra), .reg_be_i(be),
        .reg_wdata_i(wd), .sd_cke_o(cke), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n),
        .sd_cas_n_o(cas_n), .sd_we_n_o(we_n), .sd_addr_o(addr), .busy_o(busy)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; ra = a; be = b; wd = d;
        @(negedge clk);
        wr = 1'b0; be = '0;
    endtask

    // Step to the next non-NOP command, or time out with code 15
    task automatic wait_cmd(input int maxc, output logic [3:0] c, output int at,
                            output logic [AW-1:0] a, output logic k);
        c = 4'hF; at = cyc; a = '0; k = 1'b1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if ({cs_n, ras_n, cas_n, we_n} != C_NOP) begin
                c = {cs_n, ras_n, cas_n, we_n}; at = cyc; a = addr; k = cke;
                return;
            end
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R4", "command in reset", {cs_n, ras_n, cas_n, we_n}, C_NOP);
        chk(cke == 1'b1, "R4", "cke in reset", cke, 1);
        chk(busy == 1'b1, "R8", "busy in reset", busy, 1);
    endtask

    // Full initialisation sequence check (R4, R5, R1..R3)
    task automatic t_init(input int trfc, input int mode, input string tag);
        logic [3:0] c; int at, prev, t0; logic [AW-1:0] a; logic k;
        t0 = cyc;
        wait_cmd(PW + 40, c, at, a, k);
        chk(c == C_PRE, "R4", {tag, " first command is precharge"}, c, C_PRE);
        chk(at - t0 >= PW && at - t0 <= PW + 3, "R4", {tag, " power-up wait"}, at - t0, PW + 1);
        chk(a[10] == 1'b1, "R4", {tag, " precharge all A10"}, a[10], 1);
        chk(busy == 1'b1, "R8", {tag, " busy during init"}, busy, 1);
        prev = at;
        for (int i = 0; i < NREF; i++) begin
            wait_cmd(300, c, at, a, k);
            chk(c == C_REF, "R4", {tag, " refresh in init"}, c, C_REF);
            chk(at - prev == trfc + 1, "R5", {tag, " refresh spacing"}, at - prev, trfc + 1);
            prev = at;
        end
        wait_cmd(300, c, at, a, k);
        chk(c == C_LMR, "R4", {tag, " mode load"}, c, C_LMR);
        chk(at - prev == trfc + 1, "R5", {tag, " mode load spacing"}, at - prev, trfc + 1);
        chk(a[9:7] == 3'd0 && a[3] == 1'b0, "R1", {tag, " reserved mode bits"}, {a[9:7], a[3]}, 0);
        chk(a[6:4] == mode[6:4], "R2", {tag, " CAS field"}, a[6:4], mode[6:4]);
        chk(a[2:0] == mode[2:0], "R3", {tag, " burst field"}, a[2:0], mode[2:0]);
        repeat (trfc - 1) @(negedge clk);
        chk(busy == 1'b1, "R5", {tag, " busy before gap end"}, busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R5", {tag, " busy after gap end"}, busy, 0);
    endtask

    task automatic t_refresh(input int rate);
        logic [3:0] c; int at, prev; logic [AW-1:0] a; logic k;
        wait_cmd(200, c, at, a, k);
        chk(c == C_REF, "R9", "first periodic refresh", c, C_REF);
        prev = at;
        for (int i = 0; i < 3; i++) begin
            wait_cmd(200, c, at, a, k);
            chk(c == C_REF && k, "R9", "periodic refresh command", c, C_REF);
            if (i > 0) chk(at - prev == rate + 1, "R9", "refresh period", at - prev, rate + 1);
            prev = at;
        end
    endtask

    task automatic t_self_refresh(input int xsr);
        logic [3:0] c; int at, n; logic [AW-1:0] a; logic k; bit quiet;
        reg_write(2'd0, 4'b1000, 32'h8000_0000);
        wait_cmd(30, c, at, a, k);
        chk(c == C_REF, "R6", "upper write gives no restart, entry refresh", c, C_REF);
        chk(k == 1'b0, "R7", "cke low at entry", k, 0);
        quiet = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if ({cs_n, ras_n, cas_n, we_n} != C_NOP || cke) quiet = 1'b0;
        end
        chk(quiet, "R9", "no refresh and cke low during self-refresh", quiet, 1);
        chk(busy == 1'b0, "R8", "not busy while in self-refresh", busy, 0);
        reg_write(2'd0, 4'b1000, 32'h0);
        for (int i = 0; i < 10 && !cke; i++) @(negedge clk);
        chk(cke == 1'b1, "R7", "cke high after exit", cke, 1);
        n = 0; quiet = 1'b1;
        while (busy && n < 300) begin
            if ({cs_n, ras_n, cas_n, we_n} != C_NOP) quiet = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == xsr, "R8", "exit busy length", n, xsr);
        chk(quiet, "R8", "NOP during exit", quiet, 1);
        wait_cmd(200, c, at, a, k);
        chk(c == C_REF && k, "R9", "refresh resumes after exit", c, C_REF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        t_init(7, 'h032, "reset init");
        reg_write(2'd1, 4'b0011, 32'h0000_0503);
        reg_write(2'd2, 4'b0011, 32'h0000_0028);
        reg_write(2'd0, 4'b0011, 32'h0000_0001);
        t_init(3, 'h023, "byte0/1 restart R6");
        t_refresh(40);
        t_self_refresh(5);
        reg_write(2'd0, 4'b0100, 32'h0);
        t_init(3, 'h023, "byte2 restart R6");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule